// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block feeds a transmit datapath from a ring of buffer descriptors kept in system memory. Software fills descriptors, points the block at the start of the ring, and pulses an activate input while the global enable is high. The walker then reads descriptors one after another through a single memory request port. For each ready descriptor it copies the referenced buffer into a local frame store, clears the descriptor's ready flag in memory, and moves to the next descriptor.

A frame may span several descriptors. When a descriptor marked as the end of a frame has been copied, the stored frame is sent out as a byte stream with an end marker. A frame that would exceed the maximum frame size is cut at that size, and a babble event is raised. The walk ends at the first descriptor whose ready flag is clear. The pointer to that descriptor is kept, so the next activation resumes there. Single-cycle event pulses report each finished buffer, each finished frame and each truncation.

Top module: `txr_walker`

## Requirements
- R1: After reset no memory request is issued, no stream byte is valid, all event outputs are low and `desc_ptr` is 0.
- R2: While the walker is idle, a pulse on `base_wr` sets both the ring start and `desc_ptr` to `base_data` with bits 1:0 forced to 0.
- R3: An activate pulse while `enable` is low has no effect: no memory request follows and `desc_ptr` is unchanged.
- R4: A descriptor is two little-endian 32-bit words. Word 0 holds the byte length in bits 15:0 and the flags in bits 31:16. Word 1 holds the byte address of the buffer. In the flags, the ready flag is at bit 15, wrap at bit 13 and end-of-frame at bit 11 (word bits 31, 29 and 27).
- R5: The walk processes descriptors while their ready flag is set. It stops at the first descriptor whose ready flag is clear, and `desc_ptr` then holds that descriptor's address.
- R6: After a descriptor is processed, the next one is at the current address plus 8. If the wrap flag is set, the next one is at the ring start instead.
- R7: Buffer bytes are gathered in address order from any byte alignment. After the end-of-frame descriptor they leave on the stream in gathered order, with `tx_last` on the final byte. `tx_data` and `tx_last` hold while `tx_valid` is high and `tx_ready` is low.
- R8: A frame never exceeds MAX_FRAME bytes. A buffer that would overflow it is cut to the remaining room, and `evt_babble` pulses. A frame of exactly MAX_FRAME bytes raises no babble.
- R9: Every processed descriptor has word 0 written back with the ready flag cleared and all other bits unchanged. `evt_buf_done` pulses in the cycle after that write is accepted.
- R10: `evt_frame_done` pulses in the cycle after the final stream byte is accepted. A frame of zero bytes sends nothing and still pulses `evt_frame_done`.
- R11: Each activation from idle starts with an empty frame. Bytes gathered before a walk stopped without an end-of-frame descriptor are discarded.
- R12: A memory request keeps its address, direction and write data until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global transmit enable, sampled on activation |
| kick | input | 1 | Activate pulse; ignored while a walk is running |
| base_wr | input | 1 | Ring start write strobe; honoured only when idle |
| base_data | input | 32 | Ring start address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid (one per accepted read) |
| mem_rsp_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| evt_buf_done | output | 1 | Descriptor finished pulse |
| evt_frame_done | output | 1 | Frame finished pulse |
| evt_babble | output | 1 | Frame truncated pulse |
| desc_ptr | output | 32 | Current descriptor address |

## Verification
The bench builds the walker with MAX_FRAME set to 64. This lets a two-descriptor frame overflow the store, and lets a single 64-byte buffer hit the exact-fit boundary without babble. It uses a four-entry ring whose last entry carries the wrap flag. A handful of activations therefore reaches the wrap, stops on a cleared descriptor, discards a frame left open, and sends a zero-length frame. Both the memory acceptance and the stream sink stall on a fixed pattern, so held requests and held stream bytes occur throughout.

// File: rtl/txr_pkg.sv
package txr_pkg;
  // flag positions inside the 16-bit flags half of descriptor word 0
  localparam int FLG_READY = 15;
  localparam int FLG_WRAP  = 13;
  localparam int FLG_LAST  = 11;
  localparam int DESC_STRIDE = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_W0_REQ, S_W0_WAIT, S_W1_REQ, S_W1_WAIT,
    S_CP_REQ, S_CP_WAIT, S_DECIDE, S_EMIT, S_WB_REQ
  } walk_state_e;

  function automatic logic [31:0] next_desc_addr(input logic [31:0] cur,
                                                 input logic [31:0] base,
                                                 input logic        wrap);
    return wrap ? base : cur + 32'(DESC_STRIDE);
  endfunction

  function automatic logic [15:0] clip_len(input logic [15:0] want,
                                           input logic [15:0] room);
    return (want > room) ? room : want;
  endfunction

  // bytes usable from one aligned word given start lane and bytes still owed
  function automatic logic [2:0] lane_take(input logic [1:0]  off,
                                           input logic [15:0] left);
    logic [2:0] avail;
    avail = 3'd4 - {1'b0, off};
    return (left < {13'd0, avail}) ? left[2:0] : avail;
  endfunction
endpackage

// File: rtl/txr_frame_store.sv
module txr_frame_store #(
  parameter int DEPTH = 2048,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_word,
  input  logic [1:0]    wr_off,
  input  logic [2:0]    wr_cnt,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < 4; k++) begin
        if (3'(k) < wr_cnt) begin
          mem[wr_idx + IW'(k)] <= 8'(wr_word >> 5'({wr_off + 2'(k), 3'b000}));
        end
      end
    end
  end

  assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/txr_emitter.sv
module txr_emitter #(
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [15:0]   len,
  output logic [IW-1:0] rd_idx,
  input  logic [7:0]    rd_byte,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          done
);
  logic        active_q;
  logic [15:0] idx_q;
  logic [15:0] len_q;
  logic        at_end;

  assign at_end   = (idx_q == len_q - 16'd1);
  assign tx_valid = active_q;
  assign tx_data  = rd_byte;
  assign tx_last  = active_q && at_end;
  assign rd_idx   = IW'(idx_q);
  assign done     = active_q && tx_ready && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      len_q    <= len;
    end else if (active_q && tx_ready) begin
      if (at_end) active_q <= 1'b0;
      else        idx_q    <= idx_q + 16'd1;
    end
  end
endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
#(
  parameter int MAX_FRAME = 2048,
  parameter int IW        = $clog2(MAX_FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          kick,
  input  logic          base_wr,
  input  logic [31:0]   base_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [31:0]   mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_rdata,
  output logic          st_wr_en,
  output logic [IW-1:0] st_wr_idx,
  output logic [31:0]   st_wr_word,
  output logic [1:0]    st_wr_off,
  output logic [2:0]    st_wr_cnt,
  output logic          emit_go,
  output logic [15:0]   emit_len,
  input  logic          emit_done,
  output logic          evt_buf_done,
  output logic          evt_frame_done,
  output logic          evt_babble,
  output logic [31:0]   desc_ptr
);
  localparam logic [15:0] MAXF16 = 16'(MAX_FRAME);

  walk_state_e st_q;
  logic [31:0] base_q, cur_q, w0_q, src_q;
  logic [15:0] left_q, flen_q;
  logic        go_q, ev_buf_q, ev_frame_q, ev_bab_q;

  logic [15:0] room, eff_len;
  logic [2:0]  take;
  logic [15:0] take16;

  assign room    = MAXF16 - flen_q;
  assign eff_len = clip_len(w0_q[15:0], room);
  assign take    = lane_take(src_q[1:0], left_q);
  assign take16  = {13'd0, take};

  // memory request mux
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = cur_q;
    mem_req_wdata = 32'd0;
    unique case (st_q)
      S_W0_REQ: mem_req_valid = 1'b1;
      S_W1_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = cur_q + 32'd4;
      end
      S_CP_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = src_q & ~32'd3;
      end
      S_WB_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_wdata = w0_q & ~(32'd1 << (16 + FLG_READY));
      end
      default: ;
    endcase
  end

  assign st_wr_en   = (st_q == S_CP_WAIT) && mem_rsp_valid;
  assign st_wr_idx  = IW'(flen_q);
  assign st_wr_word = mem_rsp_rdata;
  assign st_wr_off  = src_q[1:0];
  assign st_wr_cnt  = take;

  assign emit_go        = go_q;
  assign emit_len       = flen_q;
  assign evt_buf_done   = ev_buf_q;
  assign evt_frame_done = ev_frame_q;
  assign evt_babble     = ev_bab_q;
  assign desc_ptr       = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      base_q     <= '0;
      cur_q      <= '0;
      w0_q       <= '0;
      src_q      <= '0;
      left_q     <= '0;
      flen_q     <= '0;
      go_q       <= 1'b0;
      ev_buf_q   <= 1'b0;
      ev_frame_q <= 1'b0;
      ev_bab_q   <= 1'b0;
    end else begin
      go_q       <= 1'b0;
      ev_buf_q   <= 1'b0;
      ev_frame_q <= 1'b0;
      ev_bab_q   <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (base_wr) begin
            base_q <= base_data & ~32'd3;
            cur_q  <= base_data & ~32'd3;
          end else if (kick && enable) begin
            flen_q <= '0;
            st_q   <= S_W0_REQ;
          end
        end
        S_W0_REQ: if (mem_req_ready) st_q <= S_W0_WAIT;
        S_W0_WAIT: begin
          if (mem_rsp_valid) begin
            w0_q <= mem_rsp_rdata;
            st_q <= mem_rsp_rdata[16 + FLG_READY] ? S_W1_REQ : S_IDLE;
          end
        end
        S_W1_REQ: if (mem_req_ready) st_q <= S_W1_WAIT;
        S_W1_WAIT: begin
          if (mem_rsp_valid) begin
            src_q    <= mem_rsp_rdata;
            left_q   <= eff_len;
            ev_bab_q <= (w0_q[15:0] > room);
            st_q     <= (eff_len == 16'd0) ? S_DECIDE : S_CP_REQ;
          end
        end
        S_CP_REQ: if (mem_req_ready) st_q <= S_CP_WAIT;
        S_CP_WAIT: begin
          if (mem_rsp_valid) begin
            src_q  <= src_q + 32'(take);
            left_q <= left_q - take16;
            flen_q <= flen_q + take16;
            st_q   <= (left_q == take16) ? S_DECIDE : S_CP_REQ;
          end
        end
        S_DECIDE: begin
          if (w0_q[16 + FLG_LAST]) begin
            if (flen_q != 16'd0) begin
              go_q <= 1'b1;
              st_q <= S_EMIT;
            end else begin
              ev_frame_q <= 1'b1;
              st_q       <= S_WB_REQ;
            end
          end else begin
            st_q <= S_WB_REQ;
          end
        end
        S_EMIT: begin
          if (emit_done) begin
            ev_frame_q <= 1'b1;
            flen_q     <= '0;
            st_q       <= S_WB_REQ;
          end
        end
        S_WB_REQ: begin
          if (mem_req_ready) begin
            ev_buf_q <= 1'b1;
            cur_q    <= next_desc_addr(cur_q, base_q, w0_q[16 + FLG_WRAP]);
            st_q     <= S_W0_REQ;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txr_walker.sv
module txr_walker #(
  parameter int MAX_FRAME = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        kick,
  input  logic        base_wr,
  input  logic [31:0] base_data,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_we,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        evt_buf_done,
  output logic        evt_frame_done,
  output logic        evt_babble,
  output logic [31:0] desc_ptr
);
  localparam int IW = $clog2(MAX_FRAME);

  logic          st_wr_en;
  logic [IW-1:0] st_wr_idx;
  logic [31:0]   st_wr_word;
  logic [1:0]    st_wr_off;
  logic [2:0]    st_wr_cnt;
  logic [IW-1:0] st_rd_idx;
  logic [7:0]    st_rd_byte;
  logic          emit_go, emit_done;
  logic [15:0]   emit_len;

  txr_seq #(.MAX_FRAME(MAX_FRAME), .IW(IW)) seq_i (
    .clk, .rst_n, .enable, .kick, .base_wr, .base_data,
    .mem_req_valid, .mem_req_ready, .mem_req_we, .mem_req_addr,
    .mem_req_wdata, .mem_rsp_valid, .mem_rsp_rdata,
    .st_wr_en, .st_wr_idx, .st_wr_word, .st_wr_off, .st_wr_cnt,
    .emit_go, .emit_len, .emit_done,
    .evt_buf_done, .evt_frame_done, .evt_babble, .desc_ptr
  );

  txr_frame_store #(.DEPTH(MAX_FRAME), .IW(IW)) store_i (
    .clk, .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_word(st_wr_word),
    .wr_off(st_wr_off), .wr_cnt(st_wr_cnt),
    .rd_idx(st_rd_idx), .rd_byte(st_rd_byte)
  );

  txr_emitter #(.IW(IW)) emit_i (
    .clk, .rst_n, .go(emit_go), .len(emit_len),
    .rd_idx(st_rd_idx), .rd_byte(st_rd_byte),
    .tx_valid, .tx_ready, .tx_data, .tx_last, .done(emit_done)
  );
endmodule

// File: rtl/txr_walker_chk.sv
module txr_walker_chk #(
  parameter int MAX_FRAME = 2048
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_we,
  input logic [31:0] mem_req_addr,
  input logic [31:0] mem_req_wdata,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        evt_buf_done,
  input logic        evt_frame_done,
  input logic        evt_babble
);
  logic [15:0] sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sent_q <= '0;
    else if (tx_valid && tx_ready) sent_q <= tx_last ? 16'd0 : sent_q + 16'd1;
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  assert_wb_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> !mem_req_wdata[31]);

  assert_buf_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we && mem_req_ready |=> evt_buf_done);

  assert_frame_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> evt_frame_done);

  assert_frame_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |-> sent_q < 16'(MAX_FRAME));

  assert_evt_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_buf_done, evt_frame_done, evt_babble}));
endmodule

bind txr_walker txr_walker_chk #(.MAX_FRAME(MAX_FRAME)) chk_i (.*);

// File: tb/txr_walker_tb_top.sv
`timescale 1ns/1ps
module txr_walker_tb_top;
  localparam int MAXF = 64;
  localparam logic [15:0] F_RDY  = 16'h8000;
  localparam logic [15:0] F_WRAP = 16'h2000;
  localparam logic [15:0] F_LAST = 16'h0800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, kick = 1'b0, base_wr = 1'b0;
  logic [31:0] base_data = '0;
  logic mem_req_valid, mem_req_we;
  logic mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic tx_valid, tx_last;
  logic tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic evt_buf_done, evt_frame_done, evt_babble;
  logic [31:0] desc_ptr;

  always #2 clk = ~clk;

  txr_walker #(.MAX_FRAME(MAXF)) dut_i (.*);

  logic [7:0] bmem [4096];
  logic [8:0] exp_q [$];
  int checks = 0, failures = 0;
  int n_buf = 0, n_frame = 0, n_bab = 0, n_req = 0;
  int cyc = 0;
  logic rsp_pend = 1'b0;
  logic [31:0] rsp_word = '0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(input logic [31:0] a);
    logic [11:0] b;
    b = a[11:0] & 12'hffc;
    return {bmem[b + 12'd3], bmem[b + 12'd2], bmem[b + 12'd1], bmem[b]};
  endfunction

  task automatic wr32(input logic [31:0] a, input logic [31:0] d);
    logic [11:0] b;
    b = a[11:0] & 12'hffc;
    bmem[b] = d[7:0]; bmem[b + 12'd1] = d[15:8];
    bmem[b + 12'd2] = d[23:16]; bmem[b + 12'd3] = d[31:24];
  endtask

  // driver side: build descriptor and buffer, push expected bytes
  task automatic put_desc(input logic [31:0] a, input logic [15:0] flg,
                          input logic [15:0] len, input logic [31:0] buf_a);
    wr32(a, {flg, len});
    wr32(a + 32'd4, buf_a);
  endtask

  task automatic put_buf(input int a, input int n, input int seed);
    for (int i = 0; i < n; i++) bmem[a + i] = 8'(seed + i * 7);
  endtask

  task automatic expect_bytes(input int a, input int n, input bit ends);
    for (int i = 0; i < n; i++) exp_q.push_back({ends && (i == n - 1), bmem[a + i]});
  endtask

  // memory model, stream monitor, event counters
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = rsp_pend;
      mem_rsp_rdata = rsp_word;
      rsp_pend = 1'b0;
      if (evt_buf_done)   n_buf++;
      if (evt_frame_done) n_frame++;
      if (evt_babble)     n_bab++;
      if (rst_n) begin
        mem_req_ready = (cyc % 3) != 1;
        if (mem_req_valid) n_req++;
        if (mem_req_valid && mem_req_ready) begin
          if (mem_req_we) wr32(mem_req_addr, mem_req_wdata);
          else begin rsp_pend = 1'b1; rsp_word = rd32(mem_req_addr); end
        end
        tx_ready = (cyc % 4) != 2;
        if (tx_valid && tx_ready) begin
          if (exp_q.size() == 0) check(1'b0, "R7 unexpected byte", tx_data, 0);
          else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            check({tx_last, tx_data} == e, "R7 stream byte", {tx_last, tx_data}, e);
          end
        end
      end
    end
  end

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 40) begin
      @(negedge clk);
      if (mem_req_valid || tx_valid) quiet = 0;
      else quiet++;
    end
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int b0, f0, r0;
    for (int i = 0; i < 4096; i++) bmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!mem_req_valid && !tx_valid, "R1 idle outputs", {mem_req_valid, tx_valid}, 0);
    check(!evt_buf_done && !evt_frame_done && !evt_babble, "R1 events", 0, 0);
    check(desc_ptr == 32'd0, "R1 desc_ptr", desc_ptr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 ring start with low bits dropped
    base_data = 32'h103; base_wr = 1'b1;
    @(negedge clk); base_wr = 1'b0;
    @(negedge clk);
    check(desc_ptr == 32'h100, "R2 ring start", desc_ptr, 32'h100);

    // R3 activation with enable low
    put_desc(32'h100, F_RDY | F_LAST, 16'd10, 32'h400);
    put_buf(32'h400, 10, 3);
    r0 = n_req;
    pulse_kick();
    repeat (20) @(negedge clk);
    check(n_req == r0, "R3 no request when disabled", n_req - r0, 0);
    check(desc_ptr == 32'h100, "R3 pointer unchanged", desc_ptr, 32'h100);

    // R4 R5 single-buffer frame
    enable = 1'b1;
    expect_bytes(32'h400, 10, 1'b1);
    b0 = n_buf; f0 = n_frame;
    pulse_kick(); wait_idle();
    check(exp_q.size() == 0, "R7 frame 1 complete", exp_q.size(), 0);
    check(n_buf - b0 == 1 && n_frame - f0 == 1, "R9 R10 counts frame 1", {n_buf - b0, n_frame - f0}, 32'h11);
    check(desc_ptr == 32'h108, "R5 stop at cleared descriptor", desc_ptr, 32'h108);
    check(rd32(32'h100) == {F_LAST, 16'd10}, "R9 writeback frame 1", rd32(32'h100), {F_LAST, 16'd10});

    // R7 unaligned two-buffer frame
    put_desc(32'h108, F_RDY, 16'd5, 32'h501);
    put_desc(32'h110, F_RDY | F_LAST, 16'd7, 32'h603);
    put_buf(32'h500, 8, 20); put_buf(32'h600, 12, 90);
    expect_bytes(32'h501, 5, 1'b0); expect_bytes(32'h603, 7, 1'b1);
    b0 = n_buf; f0 = n_frame;
    pulse_kick(); wait_idle();
    check(exp_q.size() == 0, "R7 unaligned frame complete", exp_q.size(), 0);
    check(n_buf - b0 == 2 && n_frame - f0 == 1, "R9 R10 counts frame 2", {n_buf - b0, n_frame - f0}, 32'h21);
    check(rd32(32'h108) == {16'h0000, 16'd5}, "R9 writeback keeps length", rd32(32'h108), 5);
    check(desc_ptr == 32'h118, "R6 linear advance", desc_ptr, 32'h118);

    // R6 wrap back to ring start
    put_desc(32'h118, F_RDY | F_LAST | F_WRAP, 16'd3, 32'h700);
    put_buf(32'h700, 3, 55);
    expect_bytes(32'h700, 3, 1'b1);
    pulse_kick(); wait_idle();
    check(desc_ptr == 32'h100, "R6 wrap to ring start", desc_ptr, 32'h100);
    check(rd32(32'h118) == {F_LAST | F_WRAP, 16'd3}, "R9 writeback wrap desc", rd32(32'h118), {F_LAST | F_WRAP, 16'd3});
    check(n_bab == 0, "R8 no babble yet", n_bab, 0);

    // R8 overflow truncation: 40 + 40 cut to 64
    put_desc(32'h100, F_RDY, 16'd40, 32'h800);
    put_desc(32'h108, F_RDY | F_LAST, 16'd40, 32'h900);
    put_buf(32'h800, 40, 1); put_buf(32'h900, 40, 77);
    expect_bytes(32'h800, 40, 1'b0); expect_bytes(32'h900, MAXF - 40, 1'b1);
    pulse_kick(); wait_idle();
    check(exp_q.size() == 0, "R8 truncated frame complete", exp_q.size(), 0);
    check(n_bab == 1, "R8 babble pulse", n_bab, 1);
    check(rd32(32'h108) == {F_LAST, 16'd40}, "R9 writeback after truncation", rd32(32'h108), {F_LAST, 16'd40});

    // R11 open frame discarded
    put_desc(32'h110, F_RDY, 16'd4, 32'ha00);
    put_buf(32'ha00, 4, 200);
    f0 = n_frame;
    pulse_kick(); wait_idle();
    check(n_frame == f0 && desc_ptr == 32'h118, "R11 open frame not sent", desc_ptr, 32'h118);
    put_desc(32'h118, F_RDY | F_LAST | F_WRAP, 16'd3, 32'hb00);
    put_buf(32'hb00, 3, 150);
    expect_bytes(32'hb00, 3, 1'b1);
    pulse_kick(); wait_idle();
    check(exp_q.size() == 0 && n_frame == f0 + 1, "R11 new frame holds only new bytes", n_frame - f0, 1);

    // R10 zero-length frame
    put_desc(32'h100, F_RDY | F_LAST, 16'd0, 32'hc00);
    b0 = n_buf; f0 = n_frame;
    pulse_kick(); wait_idle();
    check(n_frame - f0 == 1 && n_buf - b0 == 1, "R10 empty frame done", {n_buf - b0, n_frame - f0}, 32'h11);
    check(desc_ptr == 32'h108, "R5 pointer after empty frame", desc_ptr, 32'h108);

    // R8 exact fit: no babble
    put_desc(32'h108, F_RDY | F_LAST, 16'(MAXF), 32'hd00);
    put_buf(32'hd00, MAXF, 9);
    expect_bytes(32'hd00, MAXF, 1'b1);
    pulse_kick(); wait_idle();
    check(exp_q.size() == 0, "R8 exact-fit frame complete", exp_q.size(), 0);
    check(n_bab == 1, "R8 exact fit raises no babble", n_bab, 1);
    check(desc_ptr == 32'h110, "R5 final pointer", desc_ptr, 32'h110);

    finish_run();
  end
endmodule